// File: doc/BRIEF.md
# Programmable Duty-Cycle Shift-Add Calculator

This block sits between a period measurement stage and a delay-line output stage in a digital duty-cycle controller. It takes a measured clock period and returns the delay after which the output clock's falling edge must be produced. The period arrives as a 6-bit count of fine delay cells. A 4-bit coarse count forms the upper bits and a 2-bit fine count forms the lower bits, and four fine cells make one coarse cell.

A 4-bit programmable code picks which binary fractions of the period are summed: one half, one quarter, one eighth and one sixteenth. The code bits gate shifted copies of the period, and two levels of small adders sum them. No look-up table is used. Only two fraction bits are kept for each term. The fraction left in the sum is dropped, and the whole number of fine cells is split into a coarse selection and a fine selection for the delay paths.

The result is registered. It changes only when a new measurement is presented, so a change to the code takes effect with the next measured period.

Top module: `duty_shift_calc`

## Requirements
- R1: While `rst` is high at a rising clock edge, `fall_coarse` and `fall_fine` become 0 on that edge.
- R2: The period operand is P = {meas_coarse, meas_fine}, with `meas_fine` as the two least significant bits, in fine-cell units.
- R3: Code bit 3 adds P/2, bit 2 adds P/4, bit 1 adds P/8 and bit 0 adds P/16. Each term counts only when its bit is 1. With code 4'b1000 the result is P>>1.
- R4: With several code bits set, the result is the sum of all enabled terms. Code 4'b1111 on P=32 gives 30 fine cells.
- R5: Each term keeps exactly two fraction bits, in quarter-cell units: (4P)>>1, (4P)>>2, (4P)>>3 and (4P)>>4. The whole result is the quarter-unit sum shifted right by two, truncated and not rounded. P=15 with code 4'b0011 gives 2, and P=63 with code 4'b0001 gives 3.
- R6: For a whole result N, `fall_coarse` = N/4 and `fall_fine` = N mod 4.
- R7: The outputs load on a rising edge only when `meas_valid` is high. Otherwise they hold, whatever the period or code inputs do.
- R8: Code 4'b0000 with `meas_valid` high loads zero into both outputs.
- R9: Every input produces a result that fits without overflow. The largest case, P=63 with code 4'b1111, gives N=58, which is `fall_coarse`=14 and `fall_fine`=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_valid | input | 1 | New measurement present; loads the result |
| meas_coarse | input | 4 | Measured period, coarse cells |
| meas_fine | input | 2 | Measured period, fine cells beyond the coarse count |
| duty_code | input | 4 | Fraction select: bit3 = 1/2, bit2 = 1/4, bit1 = 1/8, bit0 = 1/16 |
| fall_coarse | output | 4 | Coarse path selection for the falling-edge delay |
| fall_fine | output | 2 | Fine path selection for the falling-edge delay |

## Verification
The only register in the path sits at the outputs. A measurement presented with `meas_valid` high at one rising edge therefore shows up on `fall_coarse` and `fall_fine` just after that edge. The bench drives inputs on the falling edge and checks at the next falling edge, which is half a cycle after the loading edge.

The hold checks work differently. The period and code are changed with `meas_valid` low, and the bench waits three edges before it checks that the outputs are unchanged. It then loads a new measurement and checks that the new value appears after one edge.

// File: rtl/duty_calc_pkg.sv
package duty_calc_pkg;

    localparam int COARSE_W  = 4;
    localparam int FINE_W    = 2;
    localparam int PERIOD_W  = COARSE_W + FINE_W;
    localparam int NTERMS    = 4;
    localparam int FRAC_KEEP = 2;
    localparam int TERM_W    = PERIOD_W + FRAC_KEEP;
    localparam int PAIR_W    = TERM_W + 1;
    localparam int SUM_W     = TERM_W + 2;
    localparam int WHOLE_W   = SUM_W - FRAC_KEEP;

    typedef logic [PERIOD_W-1:0] period_t;
    typedef logic [TERM_W-1:0]   term_t;

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
    } delay_sel_t;

    // Period in quarter-cell units, divided by 2**shift, two fraction bits kept.
    function automatic term_t scaled_term(period_t p, int unsigned shift);
        term_t v;
        v = {p, {FRAC_KEEP{1'b0}}};
        return v >> shift;
    endfunction

endpackage

// File: rtl/duty_term_gate.sv
module duty_term_gate
    import duty_calc_pkg::*;
(
    input  period_t                 period,
    input  logic [NTERMS-1:0]       code,
    output term_t [NTERMS-1:0]      terms
);
    // Term g uses code bit NTERMS-1-g and a right shift of g+1.
    for (genvar g = 0; g < NTERMS; g++) begin : g_term
        assign terms[g] = code[NTERMS-1-g] ? scaled_term(period, g + 1) : '0;
    end
endmodule

// File: rtl/duty_sum.sv
module duty_sum
    import duty_calc_pkg::*;
(
    input  term_t [NTERMS-1:0]  terms,
    output logic [SUM_W-1:0]    sum
);
    logic [PAIR_W-1:0] pair_big;
    logic [PAIR_W-1:0] pair_small;

    always_comb begin
        pair_big   = PAIR_W'(terms[0]) + PAIR_W'(terms[1]);
        pair_small = PAIR_W'(terms[2]) + PAIR_W'(terms[3]);
        sum        = SUM_W'(pair_big) + SUM_W'(pair_small);
    end
endmodule

// File: rtl/duty_sel_reg.sv
module duty_sel_reg
    import duty_calc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SUM_W-1:0]  sum,
    output delay_sel_t        sel
);
    logic [WHOLE_W-1:0]  whole;
    delay_sel_t          next_sel;
    logic [FRAC_KEEP-1:0] frac_unused;
    logic [WHOLE_W-PERIOD_W-1:0] top_unused;

    always_comb begin
        whole       = sum[SUM_W-1:FRAC_KEEP];
        frac_unused = sum[FRAC_KEEP-1:0];
        top_unused  = whole[WHOLE_W-1:PERIOD_W];
        next_sel    = whole[PERIOD_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= '0;
        end else if (load) begin
            sel <= next_sel;
        end
    end
endmodule

// File: rtl/duty_shift_calc.sv
module duty_shift_calc
    import duty_calc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 meas_valid,
    input  logic [COARSE_W-1:0]  meas_coarse,
    input  logic [FINE_W-1:0]    meas_fine,
    input  logic [NTERMS-1:0]    duty_code,
    output logic [COARSE_W-1:0]  fall_coarse,
    output logic [FINE_W-1:0]    fall_fine
);
    period_t            period;
    term_t [NTERMS-1:0] terms;
    logic [SUM_W-1:0]   sum;
    delay_sel_t         sel;

    assign period = {meas_coarse, meas_fine};

    duty_term_gate u_gate (
        .period (period),
        .code   (duty_code),
        .terms  (terms)
    );

    duty_sum u_sum (
        .terms (terms),
        .sum   (sum)
    );

    duty_sel_reg u_reg (
        .clk  (clk),
        .rst  (rst),
        .load (meas_valid),
        .sum  (sum),
        .sel  (sel)
    );

    assign fall_coarse = sel.coarse;
    assign fall_fine   = sel.fine;
endmodule

// File: rtl/duty_shift_calc_chk.sv
module duty_shift_calc_chk (
    input logic       clk,
    input logic       rst,
    input logic       meas_valid,
    input logic [3:0] meas_coarse,
    input logic [1:0] meas_fine,
    input logic [3:0] duty_code,
    input logic [3:0] fall_coarse,
    input logic [1:0] fall_fine
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (fall_coarse == 4'd0 && fall_fine == 2'd0));

    p_half_term_r3: assert property (@(posedge clk) disable iff (rst)
        (meas_valid && duty_code == 4'b1000) |=>
        ({fall_coarse, fall_fine} == ($past({meas_coarse, meas_fine}) >> 1)));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !meas_valid |=> $stable({fall_coarse, fall_fine}));

    p_zero_code_r8: assert property (@(posedge clk) disable iff (rst)
        (meas_valid && duty_code == 4'b0000) |=>
        (fall_coarse == 4'd0 && fall_fine == 2'd0));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        fall_coarse <= 4'd14);
endmodule

bind duty_shift_calc duty_shift_calc_chk u_chk (.*);

// File: tb/tb_duty_shift_calc.sv
module tb_duty_shift_calc;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst;
    logic       meas_valid;
    logic [3:0] meas_coarse;
    logic [1:0] meas_fine;
    logic [3:0] duty_code;
    logic [3:0] fall_coarse;
    logic [1:0] fall_fine;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    duty_shift_calc dut (
        .clk(clk), .rst(rst), .meas_valid(meas_valid),
        .meas_coarse(meas_coarse), .meas_fine(meas_fine),
        .duty_code(duty_code), .fall_coarse(fall_coarse), .fall_fine(fall_fine)
    );

    // Expected whole fine-cell count from the requirement arithmetic.
    function automatic int expect_n(int p, logic [3:0] code);
        int q = 0;
        for (int k = 1; k <= 4; k++) begin
            if (code[4-k]) q += (p * 4) >> k;
        end
        return q >> 2;
    endfunction

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic check_sel(string req, int n);
        check(req, int'(fall_coarse), n / 4);
        check(req, int'(fall_fine), n % 4);
    endtask

    task automatic load(int p, logic [3:0] code);
        @(negedge clk);
        meas_coarse = 4'(p >> 2);
        meas_fine   = 2'(p & 3);
        duty_code   = code;
        meas_valid  = 1'b1;
        @(negedge clk);
        meas_valid  = 1'b0;
    endtask

    task automatic t_reset_r1();
        load(45, 4'b1111);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check_sel("R1 reset clears", 0);
    endtask

    task automatic t_operand_r2();
        load(22, 4'b1000);               // coarse 5, fine 2
        check_sel("R2 half of {5,2}", 11);
        load(22, 4'b0100);
        check_sel("R2 quarter of {5,2}", 5);
    endtask

    task automatic t_single_r3();
        load(40, 4'b1000); check_sel("R3 bit3 P=40", 20);
        load(40, 4'b0100); check_sel("R3 bit2 P=40", 10);
        load(40, 4'b0010); check_sel("R3 bit1 P=40", 5);
        load(40, 4'b0001); check_sel("R3 bit0 P=40", 2);
    endtask

    task automatic t_sum_r4();
        load(32, 4'b1111); check_sel("R4 P=32 all", 30);
        load(32, 4'b1100); check_sel("R4 P=32 1100", expect_n(32, 4'b1100));
        load(50, 4'b1011); check_sel("R4 P=50 1011", expect_n(50, 4'b1011));
        load(37, 4'b0110); check_sel("R4 P=37 0110", expect_n(37, 4'b0110));
    endtask

    task automatic t_trunc_r5();
        load(15, 4'b0011); check_sel("R5 P=15 0011", 2);
        load(63, 4'b0001); check_sel("R5 P=63 0001", 3);
        load(27, 4'b1101); check_sel("R5 P=27 1101", expect_n(27, 4'b1101));
    endtask

    task automatic t_split_r6();
        load(61, 4'b1000); check_sel("R6 split N=30", 30);
        load(7, 4'b1000);  check_sel("R6 split N=3", 3);
    endtask

    task automatic t_hold_r7();
        load(40, 4'b1000);
        @(negedge clk);
        meas_coarse = 4'd3; meas_fine = 2'd1; duty_code = 4'b0001;
        repeat (3) @(negedge clk);
        check_sel("R7 hold without meas_valid", 20);
        load(13, 4'b0001);
        check_sel("R7 new measurement takes effect", expect_n(13, 4'b0001));
    endtask

    task automatic t_zero_r8();
        load(55, 4'b0000); check_sel("R8 zero code", 0);
    endtask

    task automatic t_max_r9();
        load(63, 4'b1111); check_sel("R9 max operand", 58);
    endtask

    initial begin
        rst = 1'b1; meas_valid = 1'b0;
        meas_coarse = '0; meas_fine = '0; duty_code = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_sel("R1 state after reset", 0);
        t_operand_r2();
        t_single_r3();
        t_sum_r4();
        t_trunc_r5();
        t_split_r6();
        t_hold_r7();
        t_zero_r8();
        t_max_r9();
        t_reset_r1();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule